// File: doc/BRIEF.md
# Diagnostic Reading Calibrator

This block takes raw 16-bit converter readings from a pluggable optical module's monitoring circuit and turns them into calibrated diagnostic words. It serves four channels: module temperature, supply voltage, laser bias current and transmit optical power. Each channel has its own linear correction, built from an unsigned 8.8 fixed-point gain and a signed 16-bit two's-complement offset. The gains and offsets come in on flat calibration buses. An identity mode serves modules that calibrate themselves internally. In that mode the reading passes through unchanged.

Each calibrated result is then compared with four thresholds for its channel: high alarm, low alarm, high warning and low warning. The block raises one flag bit for each threshold crossed. A sample enters with a channel index and a valid strobe. Two clock edges later the calibrated word leaves with its channel and its flags. A new sample may enter on every cycle.

Top module: `dmon_calibrator`

## Requirements
- R1: A sample taken with `in_valid` high at a rising edge appears with `out_valid` high and the same channel index two rising edges later. Back-to-back samples are accepted on every cycle.
- R2: When `ident_mode` is low, the result is floor(gain × reading / 256) + offset. The gain of channel c is `cal_gain[c*16 +: 16]` (unsigned 8.8). The offset is `cal_offset[c*16 +: 16]` (signed two's complement). Channel codes are 0 temperature, 1 supply voltage, 2 bias current and 3 transmit power.
- R3: When `ident_mode` is high at the sample's input edge, `out_word` equals `in_raw` on every channel, whatever the calibration buses hold.
- R4: On channel 0 the reading and the result are signed. The result saturates to −32768 (0x8000) and +32767 (0x7FFF).
- R5: On channels 1 to 3 the reading and the result are unsigned. The result saturates to 0 and 65535.
- R6: `out_flags[k]` compares the result with threshold `cal_limit[(c*4+k)*16 +: 16]`. Levels k=0 (high alarm) and k=2 (high warning) flag when the result is strictly greater than the threshold. Levels k=1 (low alarm) and k=3 (low warning) flag when it is strictly less. Equality raises no flag. Channel 0 compares signed and the other channels compare unsigned.
- R7: When `out_valid` is low, `out_flags` is all zero.
- R8: After a synchronous active-low reset, `out_valid`, `out_chan`, `out_word` and `out_flags` are zero. The calibration buses must stay stable while a sample is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ident_mode | input | 1 | Pass readings through uncorrected |
| cal_gain | input | 64 | Per-channel unsigned 8.8 gain, channel c at bits c*16 |
| cal_offset | input | 64 | Per-channel signed offset, channel c at bits c*16 |
| cal_limit | input | 256 | Thresholds, channel c level k at bits (c*4+k)*16 |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 2 | Channel index of the sample |
| in_raw | input | 16 | Raw converter reading |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 2 | Channel index of the result |
| out_word | output | 16 | Calibrated, saturated result |
| out_flags | output | 4 | Threshold flags, bit k for level k |

## Verification
The bench targets the clamp edges on both sides: gain times reading above 65535 on an unsigned channel, a large negative offset on a small reading, and a doubled temperature reading on each signed extreme. A design that wraps instead of clamping would show a small or sign-flipped word in these cases. Negative temperatures checked against a small positive threshold expose a comparison done unsigned, which would raise a high flag instead of a low one. Results exactly equal to a threshold expose `>=` in place of `>`. Identity mode with nonzero calibration constants catches a bypass that still applies the gain or the offset.

// File: rtl/dmon_cal_pkg.sv
// Package: shared constants and helpers for the diagnostic calibrator.
// Assumes threshold levels alternate high/low starting with a high level.
package dmon_cal_pkg;
    localparam int unsigned LVL_HI_ALARM = 0;
    localparam int unsigned LVL_LO_ALARM = 1;
    localparam int unsigned LVL_HI_WARN  = 2;
    localparam int unsigned LVL_LO_WARN  = 3;

    // True for levels that flag on results above the threshold.
    function automatic bit level_is_upper(input int unsigned lvl);
        return (lvl % 2) == 0;
    endfunction
endpackage

// File: rtl/dmon_cal_scale.sv
// Module: first pipeline stage. It multiplies the reading by the channel
// gain, drops the fraction bits with floor rounding and adds the offset.
// Assumes the calibration buses are stable while the sample is captured.
module dmon_cal_scale #(
    parameter int DATA_W    = 16,
    parameter int FRAC_W    = 8,
    parameter int NUM_CH    = 4,
    parameter int SIGNED_CH = 0,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int ACC_W    = 2 * DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ident_mode,
    input  logic [NUM_CH*DATA_W-1:0] cal_gain,
    input  logic [NUM_CH*DATA_W-1:0] cal_offset,
    input  logic                     in_valid,
    input  logic [CH_W-1:0]          in_chan,
    input  logic [DATA_W-1:0]        in_raw,
    output logic                     s1_valid,
    output logic [CH_W-1:0]          s1_chan,
    output logic signed [ACC_W-1:0]  s1_acc
);
    localparam logic [DATA_W-1:0] UNITY = DATA_W'(1) << FRAC_W;

    logic [DATA_W-1:0]        gain_sel;
    logic [DATA_W-1:0]        offs_sel;
    logic signed [DATA_W:0]   raw_ext;
    logic signed [ACC_W-1:0]  product;
    logic signed [ACC_W-1:0]  acc_next;

    // Pick the channel constants, or unity and zero in identity mode.
    always_comb begin
        gain_sel = cal_gain[int'(in_chan)*DATA_W +: DATA_W];
        offs_sel = cal_offset[int'(in_chan)*DATA_W +: DATA_W];
        if (ident_mode) begin
            gain_sel = UNITY;
            offs_sel = '0;
        end
    end

    // Extend the reading as signed for the signed channel, unsigned otherwise.
    always_comb begin
        if (int'(in_chan) == SIGNED_CH) raw_ext = {in_raw[DATA_W-1], in_raw};
        else                            raw_ext = {1'b0, in_raw};
    end

    // Multiply, floor-shift and add the sign-extended offset.
    always_comb begin
        product  = $signed({1'b0, gain_sel}) * raw_ext;
        acc_next = (product >>> FRAC_W)
                 + ACC_W'($signed(offs_sel));
    end

    // Stage register for the accumulated value and its tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_chan  <= '0;
            s1_acc   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_chan  <= in_chan;
            s1_acc   <= acc_next;
        end
    end

    AST_STAGE_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(in_valid)) else $error("stage valid without input"); // R1
endmodule

// File: rtl/dmon_cal_clamp.sv
// Module: saturates a wide signed accumulator to a DATA_W-bit word, using a
// signed or unsigned range as selected. Purely combinational.
module dmon_cal_clamp #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 34
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic                    is_signed,
    output logic [DATA_W-1:0]       word
);
    localparam logic signed [ACC_W-1:0] S_MAX = ACC_W'((64'sd1 <<< (DATA_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] S_MIN = -ACC_W'(64'sd1 <<< (DATA_W-1));
    localparam logic signed [ACC_W-1:0] U_MAX = ACC_W'((64'sd1 <<< DATA_W) - 1);

    // Clamp into the selected range, passing in-range values through.
    always_comb begin
        word = acc[DATA_W-1:0];
        if (is_signed) begin
            if (acc > S_MAX)      word = {1'b0, {(DATA_W-1){1'b1}}};
            else if (acc < S_MIN) word = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            if (acc < 0)          word = '0;
            else if (acc > U_MAX) word = '1;
        end
    end
endmodule

// File: rtl/dmon_cal_check.sv
// Module: one threshold comparator. An upper level flags when the value is
// strictly above the threshold, a lower level when strictly below.
module dmon_cal_check #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] limit,
    input  logic              is_signed,
    input  logic              is_upper,
    output logic              hit
);
    logic gt, lt;

    // Strict ordering in the selected number format.
    always_comb begin
        if (is_signed) begin
            gt = $signed(value) > $signed(limit);
            lt = $signed(value) < $signed(limit);
        end else begin
            gt = value > limit;
            lt = value < limit;
        end
        hit = is_upper ? gt : lt;
    end
endmodule

// File: rtl/dmon_calibrator.sv
// Module: top of the diagnostic calibrator. Two stages: scale in the first,
// clamp and threshold compare in the second. Assumes the calibration buses
// stay stable while a sample is in flight.
module dmon_calibrator #(
    parameter int DATA_W    = 16,
    parameter int FRAC_W    = 8,
    parameter int NUM_CH    = 4,
    parameter int NUM_LVL   = 4,
    parameter int SIGNED_CH = 0,
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ident_mode,
    input  logic [NUM_CH*DATA_W-1:0]         cal_gain,
    input  logic [NUM_CH*DATA_W-1:0]         cal_offset,
    input  logic [NUM_CH*NUM_LVL*DATA_W-1:0] cal_limit,
    input  logic                             in_valid,
    input  logic [CH_W-1:0]                  in_chan,
    input  logic [DATA_W-1:0]                in_raw,
    output logic                             out_valid,
    output logic [CH_W-1:0]                  out_chan,
    output logic [DATA_W-1:0]                out_word,
    output logic [NUM_LVL-1:0]               out_flags
);
    import dmon_cal_pkg::*;

    localparam int ACC_W = 2 * DATA_W + 2;

    logic                    s1_valid;
    logic [CH_W-1:0]         s1_chan;
    logic signed [ACC_W-1:0] s1_acc;
    logic [DATA_W-1:0]       sat_word;
    logic                    s1_signed;
    logic [NUM_LVL-1:0]      hits;

    dmon_cal_scale #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W), .NUM_CH(NUM_CH), .SIGNED_CH(SIGNED_CH)
    ) scale_i (
        .clk(clk), .rst_n(rst_n), .ident_mode(ident_mode),
        .cal_gain(cal_gain), .cal_offset(cal_offset),
        .in_valid(in_valid), .in_chan(in_chan), .in_raw(in_raw),
        .s1_valid(s1_valid), .s1_chan(s1_chan), .s1_acc(s1_acc)
    );

    assign s1_signed = (int'(s1_chan) == SIGNED_CH);

    dmon_cal_clamp #(.DATA_W(DATA_W), .ACC_W(ACC_W)) clamp_i (
        .acc(s1_acc), .is_signed(s1_signed), .word(sat_word)
    );

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_level
        dmon_cal_check #(.DATA_W(DATA_W)) check_i (
            .value(sat_word),
            .limit(cal_limit[(int'(s1_chan)*NUM_LVL + l)*DATA_W +: DATA_W]),
            .is_signed(s1_signed),
            .is_upper(level_is_upper(l)),
            .hit(hits[l])
        );
    end

    // Output register: word, tag and flags, with flags quiet when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_word  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= s1_valid;
            out_chan  <= s1_chan;
            out_word  <= sat_word;
            out_flags <= s1_valid ? hits : '0;
        end
    end

    AST_OUT_FOLLOWS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(s1_valid) && out_chan == $past(s1_chan))) else $error("tag mismatch"); // R1
    AST_IDENT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ident_mode) |-> ##2 (out_word == $past(in_raw, 2))) else $error("identity broken"); // R3
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_flags == '0)) else $error("flags while idle"); // R7
    AST_SIGNED_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_signed && s1_acc > 0) |=> !out_word[DATA_W-1]) else $error("signed wrap"); // R4
endmodule

// File: tb/dmon_calibrator_tb_top.sv
module dmon_calibrator_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ident_mode = 1'b0;
    logic [63:0]  cal_gain;
    logic [63:0]  cal_offset;
    logic [255:0] cal_limit;
    logic         in_valid = 1'b0;
    logic [1:0]   in_chan = '0;
    logic [15:0]  in_raw = '0;
    logic         out_valid;
    logic [1:0]   out_chan;
    logic [15:0]  out_word;
    logic [3:0]   out_flags;

    logic [15:0] gain [4];
    logic [15:0] offs [4];
    logic [15:0] lim  [4][4];

    int checks = 0;
    int errors = 0;

    // expected pipeline, two samples deep
    bit          p1_v, p2_v;
    logic [1:0]  p1_c, p2_c;
    logic [15:0] p1_w, p2_w;
    logic [3:0]  p1_f, p2_f;
    string       p1_t, p2_t;

    always #5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < 4; c++) begin
            cal_gain[c*16 +: 16]   = gain[c];
            cal_offset[c*16 +: 16] = offs[c];
            for (int k = 0; k < 4; k++) cal_limit[(c*4+k)*16 +: 16] = lim[c][k];
        end
    end

    dmon_calibrator dut_i (
        .clk(clk), .rst_n(rst_n), .ident_mode(ident_mode),
        .cal_gain(cal_gain), .cal_offset(cal_offset), .cal_limit(cal_limit),
        .in_valid(in_valid), .in_chan(in_chan), .in_raw(in_raw),
        .out_valid(out_valid), .out_chan(out_chan), .out_word(out_word), .out_flags(out_flags)
    );

    function automatic logic [15:0] model_word(int c, logic [15:0] raw, bit id);
        longint r, q;
        if (id) return raw;
        r = (c == 0) ? longint'($signed(raw)) : longint'(raw);
        q = ((longint'(gain[c]) * r) >>> 8) + longint'($signed(offs[c]));
        if (c == 0) begin
            if (q > 32767)  return 16'h7FFF;
            if (q < -32768) return 16'h8000;
        end else begin
            if (q < 0)      return 16'h0000;
            if (q > 65535)  return 16'hFFFF;
        end
        return q[15:0];
    endfunction

    function automatic logic [3:0] model_flags(int c, logic [15:0] w);
        logic [3:0] f;
        longint v, t;
        for (int k = 0; k < 4; k++) begin
            v = (c == 0) ? longint'($signed(w)) : longint'(w);
            t = (c == 0) ? longint'($signed(lim[c][k])) : longint'(lim[c][k]);
            f[k] = (k % 2 == 0) ? (v > t) : (v < t);
        end
        return f;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: check the sample issued two calls ago, then drive a new one.
    task automatic step(bit v, int c, logic [15:0] raw, bit id, string tag);
        logic [15:0] w;
        if (p2_v) begin
            check(out_valid && out_chan == p2_c, "R1", "valid/chan", {out_valid, out_chan}, {1'b1, p2_c});
            check(out_word == p2_w, p2_t, "word", out_word, p2_w);
            check(out_flags == p2_f, "R6", "flags", out_flags, p2_f);
        end else begin
            check(!out_valid && out_flags == 0, "R7", "idle", {out_valid, out_flags}, 0);
        end
        p2_v = p1_v; p2_c = p1_c; p2_w = p1_w; p2_f = p1_f; p2_t = p1_t;
        w = model_word(c, raw, id);
        p1_v = v; p1_c = 2'(c); p1_w = w; p1_f = model_flags(c, w); p1_t = tag;
        in_valid = v; in_chan = 2'(c); in_raw = raw; ident_mode = id;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        step(0, 0, 16'h0, 0, "R7");
        step(0, 0, 16'h0, 0, "R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin
            gain[c] = 16'h0100; offs[c] = 16'h0;
            lim[c][0] = 16'hFFFF; lim[c][1] = 16'h0; lim[c][2] = 16'hFFFF; lim[c][3] = 16'h0;
        end
        lim[0][0] = 16'h7FFF; lim[0][1] = 16'h8000; lim[0][2] = 16'h7FFF; lim[0][3] = 16'h8000;
        p1_v = 0; p2_v = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        check(out_valid == 0 && out_chan == 0 && out_word == 0 && out_flags == 0,
              "R8", "reset", {out_valid, out_chan, out_word, out_flags}, 0);
        rst_n = 1'b1;

        // R3 identity with nonzero constants
        for (int c = 0; c < 4; c++) begin gain[c] = 16'h0321; offs[c] = 16'h0F00; end
        step(1, 0, 16'hFF00, 1, "R3");
        step(1, 1, 16'hABCD, 1, "R3");
        step(1, 2, 16'h0007, 1, "R3");
        step(1, 3, 16'hFFFF, 1, "R3");
        drain();

        // R5 unsigned clamps
        gain[1] = 16'hFFFF; offs[1] = 16'h0;
        gain[2] = 16'h0100; offs[2] = 16'h8000;
        step(1, 1, 16'hFFFF, 0, "R5");
        step(1, 2, 16'h0010, 0, "R5");
        drain();

        // R4 signed clamps and signed arithmetic
        gain[0] = 16'h0200; offs[0] = 16'h0;
        step(1, 0, 16'h7000, 0, "R4");
        step(1, 0, 16'h9000, 0, "R4");
        step(1, 0, 16'hFFF1, 0, "R4");
        drain();

        // R6 equality and signed threshold compare
        for (int k = 0; k < 4; k++) lim[1][k] = 16'd1000;
        lim[0][0] = 16'h0010; lim[0][2] = 16'h0010; lim[0][1] = 16'hFFF0; lim[0][3] = 16'hFFF0;
        step(1, 1, 16'd1000, 1, "R6");
        step(1, 1, 16'd1001, 1, "R6");
        step(1, 1, 16'd999, 1, "R6");
        step(1, 0, 16'hFF00, 1, "R6");
        step(1, 0, 16'h0011, 1, "R6");
        drain();

        // R2 random calibration, back-to-back and gapped (R1)
        for (int blk = 0; blk < 20; blk++) begin
            for (int c = 0; c < 4; c++) begin
                gain[c] = 16'($urandom);
                offs[c] = 16'($urandom);
                for (int k = 0; k < 4; k++) lim[c][k] = 16'($urandom);
            end
            if (blk % 3 == 0) gain[1] = 16'($urandom_range(0, 511));
            for (int n = 0; n < 50; n++) begin
                step(($urandom % 4) != 0, int'($urandom % 4), 16'($urandom),
                     ($urandom % 8) == 0, "R2");
            end
            drain();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule